// File: doc/BRIEF.md
# Line output power-up sequencer

This controller brings up a stereo line output without audible clicks. Each channel owns four control bits: input stage enable, intermediate stage enable, output stage enable and short removal. A start pulse on a channel walks those bits on in a fixed order. It waits a minimum settling gap and for a "signal path configured" level before the intermediate stage. It then starts an external DC offset cancellation run and waits for its completion. Only after that does it enable the output stage and finally release the output short. The two channels are independent, so they can be brought up one at a time or together.

A single shutdown request drops every enabled bit in the reverse order, one bit per clock. If the offset cancellation engine does not answer within a bounded number of cycles, the channel parks with its short still applied and flags an error. The eight bits leave the block packed into one control byte for the analogue section.

Each channel runs one state machine with these states: IDLE, GAP (input stage on, gap counting), DCREQ (intermediate stage on, request pulse), DCWAIT (waiting for done), OUTON (output stage on), RUN (short removed), FAULT (timeout) and the shutdown states DNOUT, DNMID and DNIN. The transitions are:
- IDLE to GAP on start.
- GAP to DCREQ when the gap has elapsed and the path is ready.
- DCREQ to DCWAIT unconditionally.
- DCWAIT to OUTON on done, or to FAULT on timeout.
- OUTON to RUN unconditionally.
- Any of GAP through FAULT to DNOUT on shutdown, then DNOUT to DNMID to DNIN to IDLE.

Top module: `lo_powerup_seq`

## Requirements
- R1: After reset `ctrl` is 0x00, so every stage is off and both shorts are applied, and `busy`, `dcoc_req` and `dcoc_err` are all 0.
- R2: `ctrl[7:4]` carries the left channel and `ctrl[3:0]` the right. Within each nibble the top bit is short removal, then output stage, then intermediate stage, and the lowest bit is input stage. In every per-channel vector, index 1 is left and index 0 is right.
- R3: A start pulse sampled while the channel is in IDLE sets its input stage bit at that clock edge. A start seen in any other state, including RUN and FAULT, is ignored.
- R4: The intermediate stage bit rises no earlier than GAP_CYC+1 cycles after the input stage bit, where GAP_CYC = ceil(CLK_KHZ x GAP_US / 1000). It also waits for that channel's `path_ok` to be 1.
- R5: `dcoc_req` is high for exactly the one cycle that follows the edge setting the intermediate stage bit.
- R6: The output stage bit is set at the edge where `dcoc_done` is sampled high while the channel waits, and short removal is set at the next edge.
- R7: If `dcoc_done` is not seen within DCOC_TO_CYC waiting cycles, `dcoc_err` rises for that channel. The output stage and short removal bits then stay 0 and the channel holds until shutdown.
- R8: A shutdown pulse clears short removal at the first edge, then output, intermediate and input stage on the three following edges. Shutdown takes priority over a simultaneous start.
- R9: `busy` is high from the edge that sets the input stage bit until RUN or FAULT is reached, and throughout the shutdown steps.
- R10: No channel's control nibble changes by more than one bit in any single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 2 | Per-channel power-up start pulse |
| path_ok | input | 2 | Per-channel level: signal path configured |
| shutdown | input | 1 | Request to power both channels down |
| dcoc_done | input | 2 | Per-channel offset cancellation finished |
| dcoc_req | output | 2 | Per-channel one-cycle offset cancellation request |
| ctrl | output | 8 | Packed stage control byte |
| busy | output | 2 | Per-channel sequence in progress |
| dcoc_err | output | 2 | Per-channel offset cancellation timeout |

## Verification
A wrong state register shows at the ports within one clock, because every control bit, `busy` and `dcoc_req` follow directly from the state. A stray or missed transition therefore appears as a mismatched `ctrl` nibble or request pulse at the next edge. A miscounted gap or timeout shows as the intermediate stage or error bit moving one or more cycles off the computed edge. A bad shutdown ordering shows as two bits falling in the same cycle or in the wrong order within four clocks of the request.

// File: rtl/lo_seq_pkg.sv
package lo_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GAP,
        ST_DCREQ,
        ST_DCWAIT,
        ST_OUTON,
        ST_RUN,
        ST_FAULT,
        ST_DNOUT,
        ST_DNMID,
        ST_DNIN
    } lo_state_e;

    // Bit order inside a channel nibble is fixed by the analogue decoder.
    typedef struct packed {
        logic rmv;
        logic outp;
        logic mid;
        logic inp;
    } lo_bits_t;

endpackage

// File: rtl/lo_cycle_timer.sv
module lo_cycle_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic reached
);
    localparam int W = $clog2(LIMIT + 2);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q < W'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached = (cnt_q >= W'(LIMIT));
endmodule

// File: rtl/lo_channel_fsm.sv
module lo_channel_fsm
    import lo_seq_pkg::*;
#(
    parameter int GAP_CYC = 8,
    parameter int TO_CYC  = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     path_ok,
    input  logic     shutdown,
    input  logic     dc_done,
    output lo_bits_t bits,
    output logic     dc_req,
    output logic     busy,
    output logic     err
);
    lo_state_e state_q, state_d;
    lo_bits_t  bits_q, bits_d;
    logic      gap_hit, to_hit;

    lo_cycle_timer #(.LIMIT(GAP_CYC)) i_gap_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_GAP),
        .reached (gap_hit)
    );

    lo_cycle_timer #(.LIMIT(TO_CYC - 1)) i_to_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_DCWAIT),
        .reached (to_hit)
    );

    always_comb begin
        state_d = state_q;
        bits_d  = bits_q;
        if (shutdown && (state_q inside {ST_GAP, ST_DCREQ, ST_DCWAIT,
                                         ST_OUTON, ST_RUN, ST_FAULT})) begin
            bits_d.rmv = 1'b0;
            state_d    = ST_DNOUT;
        end else if (!(shutdown && state_q == ST_IDLE)) begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    bits_d.inp = 1'b1;
                    state_d    = ST_GAP;
                end
                ST_GAP: if (gap_hit && path_ok) begin
                    bits_d.mid = 1'b1;
                    state_d    = ST_DCREQ;
                end
                ST_DCREQ: state_d = ST_DCWAIT;
                ST_DCWAIT: begin
                    if (dc_done) begin
                        bits_d.outp = 1'b1;
                        state_d     = ST_OUTON;
                    end else if (to_hit) begin
                        state_d = ST_FAULT;
                    end
                end
                ST_OUTON: begin
                    bits_d.rmv = 1'b1;
                    state_d    = ST_RUN;
                end
                ST_RUN, ST_FAULT: state_d = state_q;
                ST_DNOUT: begin
                    bits_d.outp = 1'b0;
                    state_d     = ST_DNMID;
                end
                ST_DNMID: begin
                    bits_d.mid = 1'b0;
                    state_d    = ST_DNIN;
                end
                ST_DNIN: begin
                    bits_d.inp = 1'b0;
                    state_d    = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    always_comb begin
        bits   = bits_q;
        dc_req = (state_q == ST_DCREQ);
        err    = (state_q == ST_FAULT);
        busy   = state_q inside {ST_GAP, ST_DCREQ, ST_DCWAIT, ST_OUTON,
                                 ST_DNOUT, ST_DNMID, ST_DNIN};
    end

    // Age of the input stage enable, used only to police the settling gap.
    logic [31:0] inp_age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               inp_age_q <= '0;
        else if (!bits_q.inp)     inp_age_q <= '0;
        else if (inp_age_q != '1) inp_age_q <= inp_age_q + 1'b1;
    end

    // R4
    mid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bits_q.mid) |-> (inp_age_q >= 32'(GAP_CYC)));

    // R4
    mid_after_inp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bits_q.mid) |-> $past(bits_q.inp) && $past(path_ok));

    // R6
    outp_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bits_q.outp) |-> $past(dc_done) && bits_q.mid);

    // R6
    rmv_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bits_q.rmv) |-> $past(bits_q.outp));

    // R5
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dc_req |=> !dc_req);

    // R7
    fault_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !bits_q.rmv && !bits_q.outp && bits_q.mid);

    // R10
    one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bits_q ^ $past(bits_q)) <= 1);
endmodule

// File: rtl/lo_powerup_seq.sv
module lo_powerup_seq
    import lo_seq_pkg::*;
#(
    parameter int CLK_KHZ     = 200000,
    parameter int GAP_US      = 20,
    parameter int DCOC_TO_CYC = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] start,
    input  logic [1:0] path_ok,
    input  logic       shutdown,
    input  logic [1:0] dcoc_done,
    output logic [1:0] dcoc_req,
    output logic [7:0] ctrl,
    output logic [1:0] busy,
    output logic [1:0] dcoc_err
);
    localparam int NCH     = 2;
    localparam int GAP_CYC = (CLK_KHZ * GAP_US + 999) / 1000;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        lo_bits_t nib;

        lo_channel_fsm #(
            .GAP_CYC (GAP_CYC),
            .TO_CYC  (DCOC_TO_CYC)
        ) i_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start[ch]),
            .path_ok  (path_ok[ch]),
            .shutdown (shutdown),
            .dc_done  (dcoc_done[ch]),
            .bits     (nib),
            .dc_req   (dcoc_req[ch]),
            .busy     (busy[ch]),
            .err      (dcoc_err[ch])
        );

        assign ctrl[4*ch +: 4] = nib;
    end

    // R9
    busy_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy & dcoc_err) == 2'b00);

    // R8
    shut_drop_rmv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (ctrl[7] == 1'b0) && (ctrl[3] == 1'b0));
endmodule

// File: tb/test_lo_powerup_seq.sv
`timescale 1ns/1ps
module test_lo_powerup_seq;
    localparam int  CLK_KHZ = 2050;
    localparam int  GAP_US  = 3;
    localparam int  TO_CYC  = 10;
    localparam real GAP_R   = CLK_KHZ * GAP_US / 1000.0;
    localparam int  G       = int'($ceil(GAP_R));

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] start = '0, path_ok = '0, dcoc_done = '0;
    logic       shutdown = 1'b0;
    logic [1:0] dcoc_req, busy, dcoc_err;
    logic [7:0] ctrl;

    int checks = 0, fails = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    lo_powerup_seq #(.CLK_KHZ(CLK_KHZ), .GAP_US(GAP_US), .DCOC_TO_CYC(TO_CYC))
    i_lo_powerup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .path_ok(path_ok),
        .shutdown(shutdown), .dcoc_done(dcoc_done), .dcoc_req(dcoc_req),
        .ctrl(ctrl), .busy(busy), .dcoc_err(dcoc_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Behavioural reference: phase 0 idle,1 gap,2 request,3 wait,4 output on,
    // 5 running,6 fault,7..9 shutdown steps.
    int       ph [2];
    int       cnt[2];
    logic [3:0] mb[2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin ph[c] = 0; cnt[c] = 0; mb[c] = 4'b0000; end
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (shutdown && ph[c] >= 1 && ph[c] <= 6) begin
                    mb[c][3] = 1'b0; ph[c] = 7;
                end else if (shutdown && ph[c] == 0) begin
                    ph[c] = 0;
                end else begin
                    case (ph[c])
                        0: if (start[c]) begin mb[c][0] = 1'b1; ph[c] = 1; cnt[c] = 0; end
                        1: if (cnt[c] >= G && path_ok[c]) begin mb[c][1] = 1'b1; ph[c] = 2; end
                           else cnt[c]++;
                        2: begin ph[c] = 3; cnt[c] = 0; end
                        3: if (dcoc_done[c]) begin mb[c][2] = 1'b1; ph[c] = 4; end
                           else if (cnt[c] >= TO_CYC - 1) ph[c] = 6;
                           else cnt[c]++;
                        4: begin mb[c][3] = 1'b1; ph[c] = 5; end
                        7: begin mb[c][2] = 1'b0; ph[c] = 8; end
                        8: begin mb[c][1] = 1'b0; ph[c] = 9; end
                        9: begin mb[c][0] = 1'b0; ph[c] = 0; end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Cycle-by-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (!done_flag) begin
            logic [1:0] eb, er, ee;
            for (int c = 0; c < 2; c++) begin
                eb[c] = (ph[c] >= 1 && ph[c] <= 4) || ph[c] >= 7;
                er[c] = (ph[c] == 2);
                ee[c] = (ph[c] == 6);
            end
            chk(ctrl == {mb[1], mb[0]}, "R2/R3/R4/R6/R8 ctrl vs model", ctrl, {mb[1], mb[0]});
            chk(busy == eb, "R9 busy vs model", busy, eb);
            chk(dcoc_req == er, "R5 dcoc_req vs model", dcoc_req, er);
            chk(dcoc_err == ee, "R7 dcoc_err vs model", dcoc_err, ee);
        end
    end

    task automatic finish_run();
        done_flag = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        // R1: reset state
        chk(ctrl == 8'h00 && busy == 2'b00 && dcoc_req == 2'b00 && dcoc_err == 2'b00,
            "R1 reset outputs", {busy, dcoc_req, dcoc_err, ctrl}, 0);
        rst_n = 1'b1;
        step(2);

        // Left channel full bring-up
        path_ok = 2'b11;
        start[1] = 1'b1; step(1); start[1] = 1'b0;
        chk(ctrl == 8'h10, "R3 left input stage first", ctrl, 8'h10);
        step(G);
        chk(ctrl[5] == 1'b0, "R4 intermediate not before gap", ctrl[5], 0);
        step(1);
        chk(ctrl[5] == 1'b1, "R4 intermediate after G+1 cycles", ctrl[5], 1);
        chk(dcoc_req == 2'b10, "R5 left request pulse", dcoc_req, 2'b10);
        step(1);
        chk(dcoc_req == 2'b00, "R5 request one cycle only", dcoc_req, 0);
        step(2);
        dcoc_done[1] = 1'b1; step(1); dcoc_done[1] = 1'b0;
        chk(ctrl == 8'h70, "R6 output stage on done", ctrl, 8'h70);
        step(1);
        chk(ctrl == 8'hF0, "R6 R2 short removed last, left nibble", ctrl, 8'hF0);
        start[1] = 1'b1; step(1); start[1] = 1'b0; step(2);
        chk(ctrl == 8'hF0 && busy == 2'b00, "R3 start ignored in RUN", ctrl, 8'hF0);

        // Right channel waits for path, restart ignored mid-sequence
        path_ok[0] = 1'b0;
        start[0] = 1'b1; step(1); start[0] = 1'b0;
        step(G + 10);
        chk(ctrl[1] == 1'b0 && busy[0] == 1'b1, "R4 R9 waits for path_ok", ctrl, 8'hF1);
        start[0] = 1'b1; step(1); start[0] = 1'b0;
        chk(ctrl == 8'hF1, "R3 restart ignored while busy", ctrl, 8'hF1);
        path_ok[0] = 1'b1;
        for (int i = 0; i < 20 && dcoc_req[0] == 1'b0; i++) step(1);
        step(1);
        dcoc_done[0] = 1'b1; step(1); dcoc_done[0] = 1'b0;
        step(1);
        chk(ctrl == 8'hFF, "R2 both channels running", ctrl, 8'hFF);

        // Shutdown from full power
        shutdown = 1'b1; step(1); shutdown = 1'b0;
        chk(ctrl == 8'h77 && busy == 2'b11, "R8 R9 short first", ctrl, 8'h77);
        step(1); chk(ctrl == 8'h33, "R8 output second", ctrl, 8'h33);
        step(1); chk(ctrl == 8'h11, "R8 intermediate third", ctrl, 8'h11);
        step(1); chk(ctrl == 8'h00 && busy == 2'b00, "R8 input last", ctrl, 8'h00);

        // Both together, right times out
        start = 2'b11; step(1); start = 2'b00;
        for (int i = 0; i < 20 && dcoc_req[1] == 1'b0; i++) step(1);
        step(2);
        dcoc_done[1] = 1'b1; step(1); dcoc_done[1] = 1'b0;
        step(TO_CYC + 2);
        chk(dcoc_err == 2'b01, "R7 right timeout error", dcoc_err, 2'b01);
        chk(ctrl == 8'hF3, "R7 right held with short applied", ctrl, 8'hF3);
        dcoc_done[0] = 1'b1; step(2); dcoc_done[0] = 1'b0;
        chk(ctrl == 8'hF3, "R7 late done ignored in fault", ctrl, 8'hF3);
        shutdown = 1'b1; step(1); shutdown = 1'b0;
        chk(ctrl == 8'h73, "R8 shutdown from fault step 1", ctrl, 8'h73);
        step(1); chk(ctrl == 8'h33, "R8 step 2", ctrl, 8'h33);
        step(1); chk(ctrl == 8'h11, "R8 step 3", ctrl, 8'h11);
        step(1); chk(ctrl == 8'h00 && dcoc_err == 2'b00, "R8 step 4", ctrl, 8'h00);

        // Shutdown during the gap, shutdown beats a simultaneous start
        start[1] = 1'b1; step(1); start[1] = 1'b0;
        step(2);
        shutdown = 1'b1; start[0] = 1'b1; step(1); shutdown = 1'b0; start[0] = 1'b0;
        chk(ctrl == 8'h10, "R8 start loses to shutdown", ctrl, 8'h10);
        step(3);
        chk(ctrl == 8'h00 && busy == 2'b00, "R8 gap shutdown done", ctrl, 8'h00);
        step(2);
        finish_run();
    end
endmodule